// File: doc/BRIEF.md
# Multi-Track Record and Replay Sequencer

This block sequences recording to and replay from one of sixteen audio tracks held in an external word-addressed memory. A four-bit selector picks the track, and two level-sensitive switches request recording and replay. The block watches the edge count that the audio shift buffer produces. It starts an accepted operation only when that count is aligned. It then issues one 16-bit memory access per buffer period until a full pass of the track has been covered.

When the request is still held at the end of a pass, the block re-arms and runs the pass again, so the track loops. Two indicator outputs show whether a record or a replay pass is under way. A seven-segment code shows the currently selected track as a hex digit. The memory controller and the audio datapath sit outside this block. The block only forms requests and addresses, and forwards the buffer word to be written.

Top module: `track_looper_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both indicators are 0 and no memory request is issued.
- R2: While idle, a held replay switch is accepted ahead of a held record switch; with both held, the pass that follows is a read pass.
- R3: An accepted request first waits until the buffer edge count equals 1. The matching indicator stays 0 through the cycle in which the count is 1 and reads 1 from the next cycle on, and no memory request is made during the wait.
- R4: During a pass, exactly one request pulse is issued per buffer period, in the cycle where the edge count has just changed from a nonzero value to 0. A request carries write-enable 1 for a record pass and 0 for a replay pass. Write data equals the buffer word on writes and is 0 on reads.
- R5: The request address is the track number in the upper four bits, concatenated with the word index of the pass in the lower bits. The word index is 0 for the first request of a pass and rises by one per request.
- R6: After PASS_WORDS requests, the pass ends and the indicator is 0 in the next cycle. The pass runs to completion even if its switch is released mid-pass. If the switch is still held at the end, a new pass starts from word index 0 after a fresh alignment wait; if it has been released, the block stays idle.
- R7: The track number is captured when the block leaves idle, and changing the selector during a pass does not alter the addresses of that pass.
- R8: The segment output always reflects the live selector as a hex digit, bit order {g,f,e,d,c,b,a}, active high. For example, 0 gives 7'h3F, 9 gives 7'h6F and A gives 7'h77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| track_sel | input | 4 | Track selector switches |
| rec_sw | input | 1 | Record request switch |
| play_sw | input | 1 | Replay request switch |
| edge_cnt | input | 4 | Rising-edge count of the audio buffer, wraps every 16 |
| buf_word | input | 16 | Middle buffer stage word to be recorded |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 4+CNT_W | Word address {track, word index} |
| mem_wdata | output | 16 | Write data |
| rec_led | output | 1 | Record pass indicator |
| play_led | output | 1 | Replay pass indicator |
| seg_code | output | 7 | Hex segment code of the selector |

## Verification
The bench builds the block with PASS_WORDS set to 4, which makes the word counter two bits wide and the address six bits. At this size a pass ends after four buffer periods of sixteen cycles each. End of pass, looping with a held switch, release mid-pass and the return to idle all fit in a few hundred cycles. The default length of about three seconds would need millions of cycles. The counter and comparison logic are the same at both sizes, so only the terminal value changes.

// File: rtl/looper_pkg.sv
// Shared types for the track looper. Assumes a four-bit track number.
package looper_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC_WAIT,
        ST_PLAY_WAIT,
        ST_REC,
        ST_PLAY
    } loop_state_e;

endpackage

// File: rtl/looper_fsm.sv
// Pass sequencer: accepts replay ahead of record, waits for buffer
// alignment, then stays in the pass until the word counter reports the
// final request. Assumes edge_cnt is synchronous to clk.
module looper_fsm
    import looper_pkg::*;
#(
    parameter int TRACK_W = 4,
    parameter int EDGE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TRACK_W-1:0] track_sel,
    input  logic               rec_sw,
    input  logic               play_sw,
    input  logic [EDGE_W-1:0]  edge_cnt,
    input  logic               pass_done,
    output loop_state_e        state,
    output logic [TRACK_W-1:0] track_q
);

    localparam logic [EDGE_W-1:0] ALIGN_VAL = EDGE_W'(1);

    loop_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (play_sw)     state_nx = ST_PLAY_WAIT;
                else if (rec_sw) state_nx = ST_REC_WAIT;
            end
            ST_REC_WAIT:  if (edge_cnt == ALIGN_VAL) state_nx = ST_REC;
            ST_PLAY_WAIT: if (edge_cnt == ALIGN_VAL) state_nx = ST_PLAY;
            ST_REC, ST_PLAY: if (pass_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and track capture while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            track_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) track_q <= track_sel;
        end
    end

    assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && play_sw) |=> (state == ST_PLAY_WAIT));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC_WAIT && edge_cnt != ALIGN_VAL) |=> (state == ST_REC_WAIT));

    assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_REC || state == ST_PLAY) && pass_done) |=> (state == ST_IDLE));

    assert_track_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(track_q));

endmodule

// File: rtl/looper_word_ctr.sv
// Word index of the current pass. Cleared while waiting for alignment,
// advanced once per issued request, flags the final word of a pass.
module looper_word_ctr #(
    parameter int PASS_WORDS = 446000,
    parameter int CNT_W      = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PASS_WORDS - 1);

    // Final-word detection.
    always_comb last = (count == LAST_VAL);

    // Index register.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= last ? '0 : count + 1'b1;
    end

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST_VAL);

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !last) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/looper_hex_seg.sv
// Hex digit to seven-segment code, bit order {g,f,e,d,c,b,a}, active high.
module looper_hex_seg (
    input  logic [3:0] digit,
    output logic [6:0] seg
);

    // Digit lookup.
    always_comb begin
        case (digit)
            4'h0: seg = 7'h3F;  4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;  4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;  4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;  4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;  4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;  4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;  4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;  default: seg = 7'h71;
        endcase
    end

endmodule

// File: rtl/track_looper_ctrl.sv
// Top of the track looper: detects the buffer period boundary, issues one
// memory request per period during a pass, forms {track, index} addresses
// and drives indicators and the track display. Assumes PASS_WORDS >= 2.
module track_looper_ctrl
    import looper_pkg::*;
#(
    parameter int PASS_WORDS = 446000,
    parameter int DATA_W     = 16,
    parameter int EDGE_W     = 4,
    parameter int CNT_W      = $clog2(PASS_WORDS),
    parameter int ADDR_W     = 4 + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        track_sel,
    input  logic              rec_sw,
    input  logic              play_sw,
    input  logic [EDGE_W-1:0] edge_cnt,
    input  logic [DATA_W-1:0] buf_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rec_led,
    output logic              play_led,
    output logic [6:0]        seg_code
);

    loop_state_e       state;
    logic [3:0]        track_q;
    logic [EDGE_W-1:0] edge_prev;
    logic [CNT_W-1:0]  word_idx;
    logic              word_last;
    logic              slot_hit;
    logic              in_pass;
    logic              in_wait;
    logic              pass_done;

    // Previous edge count, for boundary detection.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev <= '0;
        else        edge_prev <= edge_cnt;
    end

    // Request slot and pass decode.
    always_comb begin
        slot_hit  = (edge_cnt == '0) && (edge_prev != '0);
        in_pass   = (state == ST_REC) || (state == ST_PLAY);
        in_wait   = (state == ST_REC_WAIT) || (state == ST_PLAY_WAIT);
        mem_req   = in_pass && slot_hit;
        pass_done = mem_req && word_last;
    end

    // Memory request fields and indicators.
    always_comb begin
        mem_we    = (state == ST_REC);
        mem_addr  = {track_q, word_idx};
        mem_wdata = mem_we ? buf_word : '0;
        rec_led   = (state == ST_REC);
        play_led  = (state == ST_PLAY);
    end

    looper_fsm #(.TRACK_W(4), .EDGE_W(EDGE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .track_sel (track_sel),
        .rec_sw    (rec_sw),
        .play_sw   (play_sw),
        .edge_cnt  (edge_cnt),
        .pass_done (pass_done),
        .state     (state),
        .track_q   (track_q)
    );

    looper_word_ctr #(.PASS_WORDS(PASS_WORDS), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (in_wait),
        .step  (mem_req),
        .count (word_idx),
        .last  (word_last)
    );

    looper_hex_seg u_seg (
        .digit (track_sel),
        .seg   (seg_code)
    );

    assert_req_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (edge_cnt == '0 && edge_prev != '0));

    assert_no_req_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> !mem_req);

    assert_one_led_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rec_led, play_led}) <= 1);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

// File: tb/track_looper_ctrl_bench.sv
module track_looper_ctrl_bench;

    localparam int PW = 4;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  track_sel = 4'h0;
    logic        rec_sw = 1'b0;
    logic        play_sw = 1'b0;
    logic [3:0]  edge_cnt = 4'h0;
    logic [15:0] buf_word = 16'hC300;
    logic        mem_req, mem_we, rec_led, play_led;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [6:0]  seg_code;

    int checks = 0;
    int errors = 0;
    int popped = 0;
    bit done   = 1'b0;

    typedef struct { bit we; logic [AW-1:0] addr; string tag; } exp_t;
    exp_t expq[$];

    track_looper_ctrl #(.PASS_WORDS(PW)) u_track_looper_ctrl (
        .clk(clk), .rst_n(rst_n), .track_sel(track_sel), .rec_sw(rec_sw),
        .play_sw(play_sw), .edge_cnt(edge_cnt), .buf_word(buf_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rec_led(rec_led), .play_led(play_led),
        .seg_code(seg_code)
    );

    always #4 clk = ~clk;

    // Buffer model: edge count steps every cycle, word changes per period.
    always @(negedge clk) begin
        if (rst_n) begin
            edge_cnt <= edge_cnt + 4'd1;
            if (edge_cnt == 4'd0) buf_word <= buf_word + 16'd1;
        end
    end

    function automatic logic [6:0] hex7(input logic [3:0] d);
        case (d)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B;
            4'h3: return 7'h4F; 4'h4: return 7'h66; 4'h5: return 7'h6D;
            4'h6: return 7'h7D; 4'h7: return 7'h07; 4'h8: return 7'h7F;
            4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79;
            default: return 7'h71;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: push the expected requests of npass passes.
    task automatic push_pass(input bit we, input logic [3:0] trk, input int npass, input string tag);
        for (int p = 0; p < npass; p++)
            for (int i = 0; i < PW; i++) begin
                exp_t e;
                e.we = we; e.addr = {trk, 2'(i)}; e.tag = tag;
                expq.push_back(e);
            end
    endtask

    task automatic sample();
        @(negedge clk); #2;
    endtask

    // Monitor: pop and compare each request.
    initial begin
        forever begin
            sample();
            if (rst_n && mem_req) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4", "unexpected request addr", 32'(mem_addr), 32'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    popped++;
                    check(mem_we == e.we, "R4", {e.tag, " we"}, 32'(mem_we), 32'(e.we));
                    check(mem_addr == e.addr, "R5", {e.tag, " addr"}, 32'(mem_addr), 32'(e.addr));
                    check(edge_cnt == 4'd0, "R4", "slot edge", 32'(edge_cnt), 32'h0);
                    check(mem_wdata == (e.we ? buf_word : 16'h0), "R4", "wdata",
                          32'(mem_wdata), 32'(e.we ? buf_word : 16'h0));
                end
            end
        end
    end

    task automatic finish_pass(input string req);
        wait (expq.size() == 0);
        sample();
        check(!rec_led && !play_led, req, "indicators after pass", {rec_led, play_led}, 2'b00);
        repeat (40) @(negedge clk);
        check(!rec_led && !play_led, req, "stays idle", {rec_led, play_led}, 2'b00);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sample();
        // R1 reset state
        check(!rec_led, "R1", "rec_led", rec_led, 0);
        check(!play_led, "R1", "play_led", play_led, 0);
        check(!mem_req, "R1", "mem_req", mem_req, 0);
        check(seg_code == hex7(4'h0), "R8", "seg 0", seg_code, hex7(4'h0));
        @(negedge clk); rst_n = 1'b1;

        // R3/R7/R6: record track 5, alignment wait, selector change, release mid-pass
        wait (edge_cnt == 4'd2);
        @(negedge clk);
        track_sel = 4'h5; rec_sw = 1'b1;
        push_pass(1'b1, 4'h5, 1, "rec t5");
        do begin
            sample();
            if (edge_cnt != 4'd1)
                check(!rec_led, "R3", "led during wait", rec_led, 0);
        end while (edge_cnt != 4'd1);
        check(!rec_led, "R3", "led at align cycle", rec_led, 0);
        sample();
        check(rec_led, "R3", "led after align", rec_led, 1);
        check(seg_code == hex7(4'h5), "R8", "seg 5", seg_code, hex7(4'h5));
        wait (popped == 1);
        @(negedge clk);
        track_sel = 4'h9; rec_sw = 1'b0;   // R7: pass keeps track 5
        sample();
        check(seg_code == hex7(4'h9), "R8", "seg 9", seg_code, hex7(4'h9));
        finish_pass("R6");

        // R6 loop: replay track 3 held over two passes, released in the second
        @(negedge clk);
        track_sel = 4'h3; play_sw = 1'b1;
        push_pass(1'b0, 4'h3, 2, "loop t3");
        wait (popped == 4 + 5);
        @(negedge clk); play_sw = 1'b0;
        finish_pass("R6");

        // R2 priority: both switches held on track A
        @(negedge clk);
        track_sel = 4'hA; rec_sw = 1'b1; play_sw = 1'b1;
        push_pass(1'b0, 4'hA, 1, "prio tA");
        sample();
        check(seg_code == hex7(4'hA), "R8", "seg A", seg_code, hex7(4'hA));
        wait (popped == 12 + 1);
        sample();
        check(play_led && !rec_led, "R2", "replay wins", {rec_led, play_led}, 2'b01);
        @(negedge clk); rec_sw = 1'b0; play_sw = 1'b0;
        finish_pass("R2");

        check(expq.size() == 0, "R4", "leftover expected", expq.size(), 0);
        done = 1'b1;
        summary();
    end

endmodule